// File: doc/BRIEF.md
# Widescreen Signalling Line Encoder (625-line)

This block produces the digital element stream for the widescreen signalling code carried in one blanking line of a 625-line picture. It watches line and pixel counters supplied by the video timing logic. When the signalling line arrives at the programmed start pixel, it emits a fixed 29-element run-in and a fixed 24-element start code. Fourteen data bits follow, each expanded to six elements. Elements are 200 ns long. They are timed from the 29.5 MHz pixel clock by a fractional accumulator that adds 10 per clock and wraps at 59, so an element lasts 5.9 clocks on average.

The output is a one-bit level per clock and an insert strobe. A later mixer turns these into the analog pulse, with a high element placed 500 mV above blanking. Software loads the 14-bit code through a two-byte write port. The low byte is staged first. Writing the high byte makes the word pending, and the pending word is taken into use at the start of the next signalling line. A committed word keeps being sent on every signalling line until a newer word is committed.

Top module: `wss_line_enc`

## Requirements
- R1: After reset, wss_insert and wss_level are 0.
- R2: A burst starts only when line_num equals WSS_LINE (default 23) and pix_num equals START_PIX (default 325), with mode_625 and wss_en both 1 and a word committed or pending. wss_insert rises in the clock after the edge that sees that pixel.
- R3: wss_insert stays high for exactly 809 clocks, which is 137 elements. Counting the first insert clock as n = 0, clock n carries element floor(10·n/59).
- R4: Elements 0 to 28 form the run-in 1 1111 0001 1100 0111 0001 1100 0111, with the leftmost digit sent first.
- R5: Elements 29 to 52 form the start code 0001 1110 0011 1100 0001 1111, with the leftmost digit sent first.
- R6: Data bits are sent LSB first, from bit 0 to bit 13, six elements each. A 0 is sent as 000111 and a 1 as 111000.
- R7: A write with wr_hi = 0 loads data bits 7:0 from wr_data[7:0]. A write with wr_hi = 1 loads data bits 13:8 from wr_data[5:0]. wr_data[7:6] of the high write are ignored.
- R8: A low-byte write alone never starts a burst and never changes the sent word. A high-byte write commits the pair, and the pair takes effect at the next burst start. Writes made during a burst leave that burst unchanged.
- R9: No burst occurs on any line other than WSS_LINE, or while mode_625 or wss_en is 0. wss_level is 0 whenever wss_insert is 0.
- R10: A committed word is sent again on every later signalling line until another high-byte write commits a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (29.5 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_num | input | 10 | Current line number |
| pix_num | input | 11 | Pixel count from horizontal reference |
| mode_625 | input | 1 | 1 selects 625-line operation |
| wss_en | input | 1 | Signalling enable |
| wr_en | input | 1 | Register write strobe |
| wr_hi | input | 1 | 0 selects the low data byte, 1 the high byte |
| wr_data | input | 8 | Write data |
| wss_level | output | 1 | Element level for this clock (1 = high element) |
| wss_insert | output | 1 | High while the code occupies the line |

## Verification
Every clock of each burst is compared with a model of the element index, floor(10·n/59). The test words include a mixed pattern with reserved high bits set, all zeros and all ones. These tell apart errors in the fixed header, in the biphase polarity, in the bit order and in the byte split. Bursts with no committed word, with only the low byte written, on a wrong line, and with each enable dropped check the start gating. A pair written mid-burst must leave that burst intact and then appear on the following line, which separates commit timing from write timing.

// File: rtl/wss_pkg.sv
package wss_pkg;
   localparam int unsigned RUNIN_LEN   = 29;
   localparam int unsigned SYNC_LEN    = 24;
   localparam int unsigned HDR_LEN     = RUNIN_LEN + SYNC_LEN;
   localparam int unsigned CODE_BITS   = 14;
   localparam int unsigned ELEM_PER_B  = 6;
   localparam int unsigned TOTAL_ELEMS = HDR_LEN + CODE_BITS * ELEM_PER_B;
   localparam int unsigned IDX_W       = $clog2(TOTAL_ELEMS);
   localparam int unsigned BITNO_W     = $clog2(CODE_BITS);
   localparam int unsigned SUB_W       = $clog2(ELEM_PER_B);
   // run-in followed by start code, first element at the MSB
   localparam logic [HDR_LEN-1:0] HDR_PAT = {29'h1f1c71c7, 24'h1e3c1f};
endpackage

// File: rtl/wss_elem_timer.sv
module wss_elem_timer #(
   parameter int unsigned STEP = 10,
   parameter int unsigned MOD  = 59
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned ACC_W = $clog2(MOD);

   if (STEP == 0 || STEP >= MOD) begin : g_bad_ratio
      $error("wss_elem_timer: STEP must be in 1..MOD-1");
   end

   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   sum;

   always_comb begin
      sum  = {1'b0, acc} + (ACC_W+1)'(STEP);
      tick = run && (sum >= (ACC_W+1)'(MOD));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (!run)   acc <= '0;
      else if (tick)   acc <= ACC_W'(sum - (ACC_W+1)'(MOD));
      else             acc <= ACC_W'(sum);
   end

   // R3
   acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc < ACC_W'(MOD));
   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/wss_serializer.sv
module wss_serializer
   import wss_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 tick,
   input  logic [CODE_BITS-1:0] word,
   output logic                 busy,
   output logic                 level
);
   logic [IDX_W-1:0]   idx;
   logic [BITNO_W-1:0] bit_no;
   logic [SUB_W-1:0]   sub;
   logic               in_hdr;
   logic               last;

   always_comb begin
      in_hdr = idx < IDX_W'(HDR_LEN);
      last   = idx == IDX_W'(TOTAL_ELEMS - 1);
      if (!busy)       level = 1'b0;
      else if (in_hdr) level = HDR_PAT[IDX_W'(HDR_LEN - 1) - idx];
      else             level = word[bit_no] ^ (sub >= SUB_W'(ELEM_PER_B / 2));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         bit_no <= '0;
         sub    <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         idx    <= '0;
         bit_no <= '0;
         sub    <= '0;
      end else if (busy && tick) begin
         if (last) begin
            busy <= 1'b0;
         end else begin
            idx <= idx + 1'b1;
            if (!in_hdr) begin
               if (sub == SUB_W'(ELEM_PER_B - 1)) begin
                  sub    <= '0;
                  bit_no <= bit_no + 1'b1;
               end else begin
                  sub <= sub + 1'b1;
               end
            end
         end
      end
   end

   // R3
   insert_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(idx) == IDX_W'(TOTAL_ELEMS - 1));
   // R6
   bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> bit_no < BITNO_W'(CODE_BITS));
   // R3
   hold_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !tick && !start |=> $stable(idx));
endmodule

// File: rtl/wss_word_regs.sv
module wss_word_regs
   import wss_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_hi,
   input  logic [BYTE_W-1:0]    wr_data,
   input  logic                 commit,
   output logic [CODE_BITS-1:0] act_word,
   output logic                 pend,
   output logic                 have_data
);
   localparam int unsigned HI_W = CODE_BITS - BYTE_W;

   if (HI_W == 0 || HI_W > BYTE_W) begin : g_bad_split
      $error("wss_word_regs: code width must span two bytes");
   end

   logic [BYTE_W-1:0]    stage_lo;
   logic [CODE_BITS-1:0] pend_word;
   logic                 valid;
   logic                 wr_pair;

   assign wr_pair   = wr_en && wr_hi;
   assign have_data = valid || pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_lo  <= '0;
         pend_word <= '0;
         act_word  <= '0;
         pend      <= 1'b0;
         valid     <= 1'b0;
      end else begin
         if (wr_en && !wr_hi) stage_lo <= wr_data;
         if (wr_pair) pend_word <= {wr_data[HI_W-1:0], stage_lo};
         if (commit) begin
            act_word <= pend_word;
            valid    <= 1'b1;
         end
         if (wr_pair)     pend <= 1'b1;
         else if (commit) pend <= 1'b0;
      end
   end

   // R8
   lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !wr_hi && !commit |=> pend == $past(pend));
   // R10
   keep_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid);
endmodule

// File: rtl/wss_line_enc.sv
module wss_line_enc
   import wss_pkg::*;
#(
   parameter int unsigned LINE_W    = 10,
   parameter int unsigned PIX_W     = 11,
   parameter int unsigned WSS_LINE  = 23,
   parameter int unsigned START_PIX = 325,
   parameter int unsigned STEP      = 10,
   parameter int unsigned MOD       = 59,
   parameter bit          OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_num,
   input  logic [PIX_W-1:0]  pix_num,
   input  logic              mode_625,
   input  logic              wss_en,
   input  logic              wr_en,
   input  logic              wr_hi,
   input  logic [7:0]        wr_data,
   output logic              wss_level,
   output logic              wss_insert
);
   if (START_PIX >= (1 << PIX_W) || WSS_LINE >= (1 << LINE_W)) begin : g_bad_pos
      $error("wss_line_enc: start position exceeds counter width");
   end

   logic                 busy, level, tick, start, pend, have_data;
   logic [CODE_BITS-1:0] act_word;

   assign start = !busy && mode_625 && wss_en && have_data &&
                  line_num == LINE_W'(WSS_LINE) && pix_num == PIX_W'(START_PIX);

   wss_word_regs #(.BYTE_W(8)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
      .commit(start && pend), .act_word(act_word), .pend(pend), .have_data(have_data)
   );

   wss_elem_timer #(.STEP(STEP), .MOD(MOD)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
   );

   wss_serializer u_ser (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
      .word(act_word), .busy(busy), .level(level)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wss_level  <= 1'b0;
            wss_insert <= 1'b0;
         end else begin
            wss_level  <= level;
            wss_insert <= busy;
         end
      end
   end else begin : g_out_comb
      assign wss_level  = level;
      assign wss_insert = busy;
   end

   // R2
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mode_625 && wss_en && line_num == LINE_W'(WSS_LINE)));
   // R8
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(act_word));
   // R9
   quiet_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !level);
endmodule

// File: tb/sim_wss_line_enc.sv
module sim_wss_line_enc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  line_num = '0;
   logic [10:0] pix_num = '0;
   logic        mode_625 = 1'b1;
   logic        wss_en = 1'b1;
   logic        wr_en = 1'b0;
   logic        wr_hi = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        wss_level, wss_insert;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wss_line_enc u0 (
      .clk(clk), .rst_n(rst_n), .line_num(line_num), .pix_num(pix_num),
      .mode_625(mode_625), .wss_en(wss_en), .wr_en(wr_en), .wr_hi(wr_hi),
      .wr_data(wr_data), .wss_level(wss_level), .wss_insert(wss_insert)
   );

   function automatic bit exp_level(input int n, input logic [13:0] w);
      int k, d;
      logic [28:0] runin = 29'h1f1c71c7;
      logic [23:0] sync  = 24'h1e3c1f;
      k = (n * 10) / 59;
      if (k < 29) return runin[28 - k];
      if (k < 53) return sync[23 - (k - 29)];
      d = k - 53;
      return w[d / 6] ? ((d % 6) < 3) : ((d % 6) >= 3);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input bit hi, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_hi = hi; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // walks one line; mid-burst writes of nw when midw is set
   task automatic run_line(input int ln, input bit exp_burst, input logic [13:0] w,
                           input bit midw, input logic [13:0] nw, input string req);
      int ins_bad = 0, lvl_bad = 0, ins_cnt = 0;
      int a_ins = 0, e_ins = 0, a_lvl = 0, e_lvl = 0;
      line_num = 10'(ln);
      for (int p = 0; p < 1888; p++) begin
         @(negedge clk);
         if (p > 0) begin
            int n = p - 326;
            bit ei = exp_burst && n >= 0 && n < 809;
            bit el = ei ? exp_level(n, w) : 1'b0;
            if (wss_insert) ins_cnt++;
            if (wss_insert !== ei && ins_bad == 0) begin a_ins = p; e_ins = ei; end
            if (wss_insert !== ei) ins_bad++;
            if (wss_level !== el && lvl_bad == 0) begin a_lvl = wss_level; e_lvl = el; end
            if (wss_level !== el) lvl_bad++;
         end
         pix_num = 11'(p);
         if (midw && p == 500) begin wr_en = 1'b1; wr_hi = 1'b0; wr_data = nw[7:0]; end
         if (midw && p == 502) begin wr_en = 1'b1; wr_hi = 1'b1; wr_data = {2'b11, nw[13:8]}; end
         if (midw && (p == 501 || p == 503)) wr_en = 1'b0;
      end
      check(ins_bad == 0, req, "insert window (first bad pixel / exp)", a_ins, e_ins);
      check(ins_cnt == (exp_burst ? 809 : 0), req, "insert length", ins_cnt,
            exp_burst ? 809 : 0);
      check(lvl_bad == 0, req, "element levels", a_lvl, e_lvl);
      line_num = '0;
      pix_num  = '0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(wss_insert == 1'b0, "R1", "insert after reset", wss_insert, 0);
      check(wss_level == 1'b0, "R1", "level after reset", wss_level, 0);
   endtask

   task automatic t_no_data();
      run_line(23, 1'b0, 14'h0, 1'b0, 14'h0, "R2 no word");
      write_reg(1'b0, 8'h5b);
      run_line(23, 1'b0, 14'h0, 1'b0, 14'h0, "R8 low byte only");
   endtask

   task automatic t_first_word();
      write_reg(1'b1, 8'hea); // reserved bits 7:6 set, R7
      run_line(23, 1'b1, 14'h2a5b, 1'b0, 14'h0, "R3 R4 R5 R6 R7 first word");
   endtask

   task automatic t_gating();
      run_line(22, 1'b0, 14'h2a5b, 1'b0, 14'h0, "R9 wrong line");
      mode_625 = 1'b0;
      run_line(23, 1'b0, 14'h2a5b, 1'b0, 14'h0, "R9 mode off");
      mode_625 = 1'b1; wss_en = 1'b0;
      run_line(23, 1'b0, 14'h2a5b, 1'b0, 14'h0, "R9 enable off");
      wss_en = 1'b1;
   endtask

   task automatic t_retain_and_midwrite();
      run_line(23, 1'b1, 14'h2a5b, 1'b0, 14'h0, "R10 retained");
      run_line(23, 1'b1, 14'h2a5b, 1'b1, 14'h3fff, "R8 write during burst");
      run_line(23, 1'b1, 14'h3fff, 1'b0, 14'h0, "R8 R6 ones take effect");
      write_reg(1'b0, 8'h00);
      write_reg(1'b1, 8'hc0);
      run_line(23, 1'b1, 14'h0000, 1'b0, 14'h0, "R6 R7 zeros");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_no_data();
      t_first_word();
      t_gating();
      t_retain_and_midwrite();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule